// File: doc/BRIEF.md
# Interrupt Redirection Register Window

This block holds the programmable state of an I/O interrupt controller behind a two-register bus window. Software first writes a register number into a select register at one bus offset. It then reads or writes the register that number names through a data window at a second bus offset. The registers reached this way are a controller identifier, a read-only version and size word, an arbitration identifier, and a table of redirection entries. Each table entry is 64 bits wide and is reached as two consecutive 32-bit register numbers.

The delivery logic does not go through the bus. It reads every table entry at once through flat, field-decoded output vectors. The block only stores and presents this state. It does not deliver any interrupt.

Bus accesses are single-beat. A request is taken in the cycle `req_i` is high, and its response is returned on the next cycle. Only full 32-bit accesses at the two defined offsets are accepted. Any other access receives an error response and changes nothing.

Top module: `irq_route_regs`

## Requirements
- R1: After reset, the select register reads 0, both identifier bytes are 0, and every table entry has its mask bit (low-half bit 16) set with every other field zero.
- R2: A full-word write at bus byte offset 0x00 stores all 32 bits in the select register. A read at offset 0x00 returns the stored value.
- R3: A write through the window while select = 0x0 stores wdata bits 31:24 as the controller identifier. A read returns that byte in bits 31:24 with zeros in all other bits. The `id_o` output follows the stored value.
- R4: Select = 0x1 reads back (NUM_ENTRIES-1) in bits 23:16 and the VERSION parameter in bits 7:0, with every other bit zero. A write to this register changes nothing.
- R5: Select = 0x2 is the arbitration identifier. It is held in bits 31:24 and written and read the same way as R3, and the `arb_id_o` output follows it.
- R6: Table entry n has its low half at select 0x10+2n and its high half at 0x10+2n+1. In the low half, the vector is bits 7:0, the delivery mode is bits 10:8, the destination mode is bit 11, the polarity is bit 13, the trigger mode is bit 15 and the mask is bit 16. In the high half, the destination is bits 31:24. Each field appears on its `ent_*_o` output at slice n.
- R7: A write to a low half keeps only the bits in 0x0001_AFFF and clears the rest. A write to a high half keeps only bits 31:24. A read returns the stored value.
- R8: Select values 0x3 through 0xF, and values of 0x10+2*NUM_ENTRIES and above, name no register. A window write to one of them changes no state, and a window read of one returns 0.
- R9: An access at any byte offset other than 0x00 or 0x10, or with `be_i` other than 4'hF, returns `err_o`=1 with `rdata_o`=0 and changes no state.
- R10: Every request gives exactly one response, with `rsp_valid_o` high in the cycle after `req_i`. `err_o` is low for accepted accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset within the block |
| be_i | input | 4 | Byte enables; only 4'hF is accepted |
| wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after request |
| err_o | output | 1 | Error response |
| rdata_o | output | 32 | Read data, zero on writes and errors |
| id_o | output | 8 | Controller identifier |
| arb_id_o | output | 8 | Arbitration identifier |
| ent_vector_o | output | NUM_ENTRIES*8 | Vector per entry |
| ent_dlv_mode_o | output | NUM_ENTRIES*3 | Delivery mode per entry |
| ent_dest_mode_o | output | NUM_ENTRIES | Destination mode per entry |
| ent_polarity_o | output | NUM_ENTRIES | Polarity per entry |
| ent_trigger_o | output | NUM_ENTRIES | Trigger mode per entry |
| ent_mask_o | output | NUM_ENTRIES | Mask per entry |
| ent_dest_o | output | NUM_ENTRIES*8 | Destination per entry |

## Verification
The bench aims first at the edges of the table range. Select values 0x3E and 0x3F must reach the last entry, and 0x40 must reach nothing. A design with an off-by-one bound would let 0x40 alias entry 0 or write beyond the table. Writes of all ones show whether the reserved bits and the read-only version word are properly protected. A design that got this wrong would return nonzero reserved bits or a corrupted size field. Mis-sized and mis-addressed accesses check that an error response also blocks side effects. A design that decoded the offset loosely would corrupt the select register or an entry. Random sequences then mix select changes with window traffic, so that a window access using a stale select value would show up as a wrong entry.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam logic [31:0] LO_KEEP = 32'h0001_AFFF;
  localparam logic [31:0] HI_KEEP = 32'hFF00_0000;
  localparam logic [31:0] LO_RST  = 32'h0001_0000;
  localparam int unsigned OFF_SEL = 0;
  localparam int unsigned OFF_WIN = 16;
  localparam int unsigned TAB_BASE = 16;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_ID,
    TGT_VER,
    TGT_ARB,
    TGT_TAB
  } tgt_e;

  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       trig;
    logic       pol;
    logic       dmode;
    logic [2:0] dlv;
    logic [7:0] vec;
  } entry_t;

  function automatic entry_t split_entry(logic [31:0] lo, logic [31:0] hi);
    entry_t e;
    e.vec   = lo[7:0];
    e.dlv   = lo[10:8];
    e.dmode = lo[11];
    e.pol   = lo[13];
    e.trig  = lo[15];
    e.mask  = lo[16];
    e.dest  = hi[31:24];
    return e;
  endfunction
endpackage

// File: rtl/irq_route_bus_dec.sv
module irq_route_bus_dec
  import irq_route_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  output logic              sel_wr_o,
  output logic              sel_rd_o,
  output logic              win_wr_o,
  output logic              win_rd_o,
  output logic              bad_o
);
  logic full_word, at_sel, at_win, ok;

  always_comb begin
    full_word = (be_i == 4'hF);
    at_sel    = (addr_i == ADDR_W'(OFF_SEL));
    at_win    = (addr_i == ADDR_W'(OFF_WIN));
    ok        = full_word && (at_sel || at_win);
    sel_wr_o  = req_i && ok && at_sel && we_i;
    sel_rd_o  = req_i && ok && at_sel && !we_i;
    win_wr_o  = req_i && ok && at_win && we_i;
    win_rd_o  = req_i && ok && at_win && !we_i;
    bad_o     = req_i && !ok;
  end
endmodule

// File: rtl/irq_route_idx_dec.sv
module irq_route_idx_dec
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 24,
  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic [31:0]      sel_i,
  output tgt_e             tgt_o,
  output logic [IDX_W-1:0] ent_o,
  output logic             hi_o
);
  localparam logic [31:0] TAB_END = 32'(TAB_BASE + 2 * NUM_ENTRIES);
  logic [31:0] rel;

  always_comb begin
    rel   = sel_i - 32'(TAB_BASE);
    ent_o = rel[IDX_W:1];
    hi_o  = rel[0];
    if (sel_i == 32'h0)      tgt_o = TGT_ID;
    else if (sel_i == 32'h1) tgt_o = TGT_VER;
    else if (sel_i == 32'h2) tgt_o = TGT_ARB;
    else if (sel_i >= 32'(TAB_BASE) && sel_i < TAB_END) tgt_o = TGT_TAB;
    else tgt_o = TGT_NONE;
  end
endmodule

// File: rtl/irq_route_entry.sv
module irq_route_entry
  import irq_route_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] lo_o,
  output logic [31:0] hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_o <= LO_RST;
      hi_o <= '0;
    end else begin
      if (wr_lo_i) lo_o <= wdata_i & LO_KEEP;
      if (wr_hi_i) hi_o <= wdata_i & HI_KEEP;
    end
  end

  AST_ENTRY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_lo_i || wr_hi_i) |=> ($stable(lo_o) && $stable(hi_o))) else $error("entry changed without write"); // R8
  AST_LO_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> ((lo_o & ~LO_KEEP) == 32'h0)) else $error("reserved low bits set"); // R7
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 24,
  parameter int unsigned ADDR_W      = 8,
  parameter logic [7:0]  VERSION     = 8'h11,
  parameter logic [7:0]  RESET_ID    = 8'h00
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [3:0]               be_i,
  input  logic [31:0]              wdata_i,
  output logic                     rsp_valid_o,
  output logic                     err_o,
  output logic [31:0]              rdata_o,
  output logic [7:0]               id_o,
  output logic [7:0]               arb_id_o,
  output logic [NUM_ENTRIES*8-1:0] ent_vector_o,
  output logic [NUM_ENTRIES*3-1:0] ent_dlv_mode_o,
  output logic [NUM_ENTRIES-1:0]   ent_dest_mode_o,
  output logic [NUM_ENTRIES-1:0]   ent_polarity_o,
  output logic [NUM_ENTRIES-1:0]   ent_trigger_o,
  output logic [NUM_ENTRIES-1:0]   ent_mask_o,
  output logic [NUM_ENTRIES*8-1:0] ent_dest_o
);
  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_ENTRIES - 1), 8'h00, VERSION};

  logic sel_wr, sel_rd, win_wr, win_rd, bad;
  logic [31:0] sel_q;
  logic [7:0] id_q, arb_q;
  tgt_e tgt;
  logic [IDX_W-1:0] ent_idx;
  logic hi_half;
  logic [NUM_ENTRIES-1:0] wr_lo, wr_hi;
  logic [31:0] lo_arr [NUM_ENTRIES];
  logic [31:0] hi_arr [NUM_ENTRIES];
  logic [31:0] win_data, rd_next;

  irq_route_bus_dec #(.ADDR_W(ADDR_W)) u_bus (
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .be_i(be_i),
    .sel_wr_o(sel_wr), .sel_rd_o(sel_rd), .win_wr_o(win_wr),
    .win_rd_o(win_rd), .bad_o(bad)
  );

  irq_route_idx_dec #(.NUM_ENTRIES(NUM_ENTRIES)) u_idx (
    .sel_i(sel_q), .tgt_o(tgt), .ent_o(ent_idx), .hi_o(hi_half)
  );

  for (genvar n = 0; n < NUM_ENTRIES; n++) begin : g_ent
    entry_t dec;
    assign wr_lo[n] = win_wr && (tgt == TGT_TAB) && (ent_idx == IDX_W'(n)) && !hi_half;
    assign wr_hi[n] = win_wr && (tgt == TGT_TAB) && (ent_idx == IDX_W'(n)) && hi_half;

    irq_route_entry u_entry (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_lo_i(wr_lo[n]), .wr_hi_i(wr_hi[n]),
      .wdata_i(wdata_i), .lo_o(lo_arr[n]), .hi_o(hi_arr[n])
    );

    assign dec                  = split_entry(lo_arr[n], hi_arr[n]);
    assign ent_vector_o[n*8+:8] = dec.vec;
    assign ent_dlv_mode_o[n*3+:3] = dec.dlv;
    assign ent_dest_mode_o[n]   = dec.dmode;
    assign ent_polarity_o[n]    = dec.pol;
    assign ent_trigger_o[n]     = dec.trig;
    assign ent_mask_o[n]        = dec.mask;
    assign ent_dest_o[n*8+:8]   = dec.dest;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      id_q  <= RESET_ID;
      arb_q <= RESET_ID;
    end else begin
      if (sel_wr) sel_q <= wdata_i;
      if (win_wr && tgt == TGT_ID)  id_q  <= wdata_i[31:24];
      if (win_wr && tgt == TGT_ARB) arb_q <= wdata_i[31:24];
    end
  end

  always_comb begin
    unique case (tgt)
      TGT_ID:  win_data = {id_q, 24'h0};
      TGT_VER: win_data = VER_WORD;
      TGT_ARB: win_data = {arb_q, 24'h0};
      TGT_TAB: win_data = hi_half ? hi_arr[ent_idx] : lo_arr[ent_idx];
      default: win_data = 32'h0;
    endcase
    if (sel_rd)      rd_next = sel_q;
    else if (win_rd) rd_next = win_data;
    else             rd_next = 32'h0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      err_o       <= 1'b0;
      rdata_o     <= '0;
    end else begin
      rsp_valid_o <= req_i;
      err_o       <= bad;
      rdata_o     <= rd_next;
    end
  end

  assign id_o     = id_q;
  assign arb_id_o = arb_q;

  AST_RSP_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o) else $error("missing response"); // R10
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o) else $error("response without request"); // R10
  AST_BAD_KEEPS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad |=> ($stable(sel_q) && $stable(id_q) && $stable(arb_q))) else $error("error access changed state"); // R9
  AST_ERR_ZERO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad |=> (err_o && rdata_o == 32'h0)) else $error("error response carries data"); // R9
  AST_ONE_HALF_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_lo, wr_hi})) else $error("multiple entry halves written"); // R6
  AST_ID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_wr |=> ($stable(id_q) && $stable(arb_q))) else $error("identifier changed without write"); // R3
endmodule

// File: tb/sim_irq_route_regs.sv
module sim_irq_route_regs;
  localparam int CLK_PERIOD = 10;
  localparam int N = 24;
  localparam logic [7:0] VER = 8'h11;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0;
  logic [7:0] addr_i = '0;
  logic [3:0] be_i = '0;
  logic [31:0] wdata_i = '0;
  logic rsp_valid_o, err_o;
  logic [31:0] rdata_o;
  logic [7:0] id_o, arb_id_o;
  logic [N*8-1:0] ent_vector_o, ent_dest_o;
  logic [N*3-1:0] ent_dlv_mode_o;
  logic [N-1:0] ent_dest_mode_o, ent_polarity_o, ent_trigger_o, ent_mask_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_sel;
  logic [7:0]  m_id, m_arb;
  logic [31:0] m_lo [N];
  logic [31:0] m_hi [N];

  irq_route_regs u0 (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .be_i, .wdata_i,
    .rsp_valid_o, .err_o, .rdata_o, .id_o, .arb_id_o,
    .ent_vector_o, .ent_dlv_mode_o, .ent_dest_mode_o, .ent_polarity_o,
    .ent_trigger_o, .ent_mask_o, .ent_dest_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_win(input logic [31:0] s);
    if (s == 0) return {m_id, 24'h0};
    if (s == 1) return {8'h00, 8'(N-1), 8'h00, VER};
    if (s == 2) return {m_arb, 24'h0};
    if (s >= 16 && s < 16 + 2*N) begin
      if (s[0]) return m_hi[(s-16)/2];
      return m_lo[(s-16)/2];
    end
    return 32'h0;
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    if (be != 4'hF) return;
    if (a == 8'h00) m_sel = d;
    else if (a == 8'h10) begin
      if (m_sel == 0) m_id = d[31:24];
      else if (m_sel == 2) m_arb = d[31:24];
      else if (m_sel >= 16 && m_sel < 16 + 2*N) begin
        if (m_sel[0]) m_hi[(m_sel-16)/2] = d & 32'hFF00_0000;
        else          m_lo[(m_sel-16)/2] = d & 32'h0001_AFFF;
      end
    end
  endtask

  // one access; checks response against model
  task automatic acc(input bit we, input logic [7:0] a, input logic [3:0] be,
                     input logic [31:0] d, input string req);
    logic [31:0] exp_rd;
    bit exp_err;
    exp_err = !(be == 4'hF && (a == 8'h00 || a == 8'h10));
    exp_rd = 32'h0;
    if (!we && !exp_err) exp_rd = (a == 8'h00) ? m_sel : exp_win(m_sel);
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; addr_i = a; be_i = be; wdata_i = d;
    @(posedge clk_i);
    #1;
    req_i = 1'b0;
    if (we) model_write(a, be, d);
    chk(rsp_valid_o === 1'b1, "R10 rsp_valid", 32'(rsp_valid_o), 32'h1);
    chk(err_o === exp_err, exp_err ? "R9 err" : "R10 err", 32'(err_o), 32'(exp_err));
    chk(rdata_o === exp_rd, req, rdata_o, exp_rd);
  endtask

  task automatic chk_outputs(input string req);
    for (int n = 0; n < N; n++) begin
      logic [27:0] act, exp;
      act = {ent_vector_o[n*8+:8], ent_dlv_mode_o[n*3+:3], ent_dest_mode_o[n],
             ent_polarity_o[n], ent_trigger_o[n], ent_mask_o[n], ent_dest_o[n*8+:8], 4'h0};
      exp = {m_lo[n][7:0], m_lo[n][10:8], m_lo[n][11], m_lo[n][13], m_lo[n][15],
             m_lo[n][16], m_hi[n][31:24], 4'h0};
      chk(act === exp, req, 32'(act), 32'(exp));
    end
    chk(id_o === m_id, "R3 id_o", 32'(id_o), 32'(m_id));
    chk(arb_id_o === m_arb, "R5 arb_id_o", 32'(arb_id_o), 32'(m_arb));
  endtask

  function automatic logic [31:0] pick_sel();
    int k = $urandom_range(0, 5);
    case (k)
      0: return 32'($urandom_range(0, 2));
      1: return 32'($urandom_range(3, 15));
      2, 3: return 32'($urandom_range(16, 16 + 2*N - 1));
      4: return 32'($urandom_range(16 + 2*N, 16 + 2*N + 3));
      default: return $urandom();
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    m_sel = 0; m_id = 0; m_arb = 0;
    for (int n = 0; n < N; n++) begin m_lo[n] = 32'h0001_0000; m_hi[n] = 0; end
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk(rsp_valid_o === 1'b0, "R1 rsp idle", 32'(rsp_valid_o), 32'h0);
    chk_outputs("R1 reset entries");
    acc(0, 8'h00, 4'hF, 0, "R1 select reset");
    // R4 version word and write ignored
    acc(0, 8'h10, 4'hF, 0, "R3 id read");
    acc(1, 8'h00, 4'hF, 32'h1, "R2 select write");
    acc(0, 8'h10, 4'hF, 0, "R4 version");
    acc(1, 8'h10, 4'hF, 32'hFFFF_FFFF, "R4 version write");
    acc(0, 8'h10, 4'hF, 0, "R4 version after write");
    chk_outputs("R4 no side effect");
    // R3 id
    acc(1, 8'h00, 4'hF, 32'h0, "R2 select write");
    acc(1, 8'h10, 4'hF, 32'hA5FF_FFFF, "R3 id write");
    acc(0, 8'h10, 4'hF, 0, "R3 id readback");
    // R5 arb
    acc(1, 8'h00, 4'hF, 32'h2, "R2 select write");
    acc(1, 8'h10, 4'hF, 32'h3C12_3456, "R5 arb write");
    acc(0, 8'h10, 4'hF, 0, "R5 arb readback");
    chk_outputs("R5 outputs");
    // R6 R7 first and last entry, reserved clearing
    acc(1, 8'h00, 4'hF, 32'h10, "R2 select write");
    acc(1, 8'h10, 4'hF, 32'hFFFF_FFFF, "R7 lo all ones");
    acc(0, 8'h10, 4'hF, 0, "R7 lo readback");
    acc(1, 8'h00, 4'hF, 32'h3F, "R2 select write");
    acc(1, 8'h10, 4'hF, 32'hFFFF_FFFF, "R7 hi all ones");
    acc(0, 8'h10, 4'hF, 0, "R7 hi readback last");
    acc(1, 8'h00, 4'hF, 32'h3E, "R2 select write");
    acc(1, 8'h10, 4'hF, 32'h0000_A5C3, "R6 last lo write");
    acc(0, 8'h10, 4'hF, 0, "R6 last lo readback");
    chk_outputs("R6 decoded fields");
    // R8 undefined indices just past the table and in the gap
    acc(1, 8'h00, 4'hF, 32'h40, "R2 select write");
    acc(1, 8'h10, 4'hF, 32'hFFFF_FFFF, "R8 write past table");
    acc(0, 8'h10, 4'hF, 0, "R8 read past table");
    acc(1, 8'h00, 4'hF, 32'h3, "R2 select write");
    acc(1, 8'h10, 4'hF, 32'hFFFF_FFFF, "R8 write gap");
    acc(0, 8'h10, 4'hF, 0, "R8 read gap");
    chk_outputs("R8 no side effect");
    // R9 bad offset and partial width
    acc(1, 8'h04, 4'hF, 32'h0000_0010, "R9 bad offset write");
    acc(1, 8'h00, 4'h7, 32'h0000_0010, "R9 partial write");
    acc(0, 8'h00, 4'hF, 0, "R9 select unchanged");
    acc(0, 8'h14, 4'hF, 0, "R9 bad offset read");
    // R2 full-width select
    acc(1, 8'h00, 4'hF, 32'hDEAD_BEEF, "R2 select write wide");
    acc(0, 8'h00, 4'hF, 0, "R2 select readback");
    acc(0, 8'h10, 4'hF, 0, "R8 wide select read");
    // random mix
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 5);
      case (op)
        0, 1: acc(1, 8'h00, 4'hF, pick_sel(), "R2 select write");
        2:    acc(1, 8'h10, 4'hF, $urandom(), "R6 window write");
        3:    acc(0, 8'h10, 4'hF, 0, "R6 window read");
        4:    acc(0, 8'h00, 4'hF, 0, "R2 select read");
        default: begin
          if ($urandom_range(0, 1) == 0)
            acc($urandom_range(0, 1) == 1, 8'($urandom_range(1, 255)) | 8'h01, 4'hF, $urandom(), "R9 bad offset");
          else
            acc($urandom_range(0, 1) == 1, 8'h10, 4'($urandom_range(0, 14)), $urandom(), "R9 bad width");
        end
      endcase
      if (i % 8 == 0) chk_outputs("R6 random outputs");
    end
    chk_outputs("R6 final outputs");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule